// File: doc/BRIEF.md
# Discharge Rate Band Monitor

This block sorts a sampled discharge current magnitude into bands measured against the battery's learned full capacity. It reports a 3-bit rate code on every clock. Three bands exist: below half the capacity rate, from half to twice the capacity rate, and above twice the capacity rate. The two band edges are not fixed constants. They are derived from the capacity input by a single shift, so they follow the capacity as it is relearned.

When the current rises above twice the capacity rate, the block raises an overload flag. The flag stays up for as long as the excess lasts. After the excess ends, the flag is held for a further 32 timebase ticks. With a 64 Hz tick, this hold lasts half a second. The block also drives an inhibit output. The end-of-discharge voltage sampler uses it to pause its sampling while the cell terminal is being pulled hard.

The current and capacity inputs use the same units. The tick input is a single-cycle strobe from a shared timebase.

Top module: `rate_band_monitor`

## Requirements
- R1: When the current is below floor(capacity/2), the rate code becomes 3'b000.
- R2: When the current is at least floor(capacity/2) and no more than 2×capacity, the rate code becomes 3'b001. A current exactly equal to 2×capacity gives 3'b001 and does not set the overload flag.
- R3: When the current is strictly above 2×capacity, the rate code becomes 3'b010. The codes 3'b011 to 3'b111 never appear.
- R4: The rate code is registered. It reflects the current and capacity present at the previous rising clock edge, so a change of capacity moves the band edges at the next edge.
- R5: The overload flag is set at the first rising edge at which the current is above 2×capacity. It stays set for as long as that condition holds, whatever the tick does.
- R6: Once the current is no longer above 2×capacity, the overload flag clears at the edge that samples the 32nd tick seen below the limit. Clock cycles without a tick never clear it.
- R7: A current above 2×capacity at any point during the hold restarts the hold. A further 32 ticks below the limit are then needed before the flag clears.
- R8: The inhibit output is high whenever the overload flag is set. It is also high, combinationally, in any cycle in which the current is above 2×capacity.
- R9: A synchronous active-low reset sets the rate code to 3'b000, clears the overload flag and zeroes the hold count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_mag | input | CUR_W | Discharge current magnitude |
| cap_full | input | CAP_W | Learned full capacity, in the same units as the current |
| tick | input | 1 | Single-cycle timebase strobe (64 Hz nominal) |
| rate_code | output | 3 | Rate band: 000 low, 001 mid, 010 overload |
| ovld | output | 1 | Overload flag, including the hold after the excess ends |
| edv_inhibit | output | 1 | Pauses end-of-discharge voltage sampling |

## Verification
A wrong band edge shows up on rate_code one clock after the offending current is applied. The exhaustive current sweep at several capacities therefore catches an off-by-one at either edge at once. A hold counter that is corrupt or off by one does not show up until the flag falls. That can be as many as 32 ticks after the excess ends, so the bench counts ticks exactly and checks the flag both at the 31st tick and at the 32nd. A counter that fails to restart is only visible after a second excess, which is why the hold is cut short and rerun.

// File: rtl/rbm_pkg.sv
`timescale 1ns/1ps
// Shared types for the discharge rate band monitor.
package rbm_pkg;
    typedef enum logic [2:0] {
        RATE_LOW  = 3'b000,
        RATE_MID  = 3'b001,
        RATE_OVER = 3'b010
    } rate_code_e;
endpackage

// File: rtl/rbm_thresholds.sv
`timescale 1ns/1ps
// rbm_thresholds: derives the half-rate and double-rate band edges from the
// learned capacity. Assumes CMP_W >= CAP_W + 1 so the doubled edge never
// loses its top bit.
module rbm_thresholds #(
    parameter int CAP_W = 16,
    parameter int CMP_W = 17
) (
    input  logic [CAP_W-1:0] cap_full,
    output logic [CMP_W-1:0] half_edge,
    output logic [CMP_W-1:0] dbl_edge
);
    logic [CMP_W-1:0] cap_x;

    // Widen the capacity, then shift it one place each way.
    always_comb begin
        cap_x     = CMP_W'(cap_full);
        half_edge = cap_x >> 1;
        dbl_edge  = cap_x << 1;
    end
endmodule

// File: rtl/rbm_band_classify.sv
`timescale 1ns/1ps
// rbm_band_classify: compares the widened current against both edges and
// picks the band code. Assumes the edges come from rbm_thresholds. A current
// equal to the doubled edge stays in the middle band.
module rbm_band_classify
    import rbm_pkg::*;
#(
    parameter int CMP_W = 17
) (
    input  logic [CMP_W-1:0] cur_x,
    input  logic [CMP_W-1:0] half_edge,
    input  logic [CMP_W-1:0] dbl_edge,
    output logic             above_dbl,
    output rate_code_e       code_next
);
    // Band decision: strict greater-than at the top edge, at-least at the bottom.
    always_comb begin
        above_dbl = (cur_x > dbl_edge);
        if (above_dbl)
            code_next = RATE_OVER;
        else if (cur_x >= half_edge)
            code_next = RATE_MID;
        else
            code_next = RATE_LOW;
    end
endmodule

// File: rtl/rbm_overload_hold.sv
`timescale 1ns/1ps
// rbm_overload_hold: sets the overload flag while the current is above the
// doubled edge. After the excess ends it keeps the flag for HOLD_TICKS
// timebase ticks. Any excess restarts the count. Assumes tick is a
// single-cycle strobe.
module rbm_overload_hold #(
    parameter int HOLD_TICKS = 32,
    localparam int CNT_W = $clog2(HOLD_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_dbl,
    input  logic tick,
    output logic ovld_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

    logic [CNT_W-1:0] hold_cnt;

    // Flag and hold counter: excess restarts, ticks advance, the last tick clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovld_q   <= 1'b0;
            hold_cnt <= '0;
        end else if (above_dbl) begin
            ovld_q   <= 1'b1;
            hold_cnt <= '0;
        end else if (ovld_q && tick) begin
            if (hold_cnt == LAST) begin
                ovld_q   <= 1'b0;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rate_band_monitor.sv
`timescale 1ns/1ps
// rate_band_monitor: top level. Classifies the discharge current against
// bands scaled from the learned capacity, registers the band code, holds an
// overload flag and drives the end-of-discharge sampling inhibit.
// Assumes current and capacity are in the same units.
module rate_band_monitor
    import rbm_pkg::*;
#(
    parameter int CUR_W      = 16,
    parameter int CAP_W      = 16,
    parameter int HOLD_TICKS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CUR_W-1:0] cur_mag,
    input  logic [CAP_W-1:0] cap_full,
    input  logic             tick,
    output logic [2:0]       rate_code,
    output logic             ovld,
    output logic             edv_inhibit
);
    localparam int CMP_W = (CUR_W > CAP_W + 1) ? CUR_W : CAP_W + 1;

    logic [CMP_W-1:0] half_edge;
    logic [CMP_W-1:0] dbl_edge;
    logic [CMP_W-1:0] cur_x;
    logic             above_dbl;
    rate_code_e       code_next;
    rate_code_e       code_q;
    logic             ovld_q;

    // Widen the current to the comparison width.
    always_comb cur_x = CMP_W'(cur_mag);

    rbm_thresholds #(.CAP_W(CAP_W), .CMP_W(CMP_W)) i_thr (
        .cap_full (cap_full),
        .half_edge(half_edge),
        .dbl_edge (dbl_edge)
    );

    rbm_band_classify #(.CMP_W(CMP_W)) i_cls (
        .cur_x    (cur_x),
        .half_edge(half_edge),
        .dbl_edge (dbl_edge),
        .above_dbl(above_dbl),
        .code_next(code_next)
    );

    rbm_overload_hold #(.HOLD_TICKS(HOLD_TICKS)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .above_dbl(above_dbl),
        .tick     (tick),
        .ovld_q   (ovld_q)
    );

    // Band code register.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= RATE_LOW;
        else        code_q <= code_next;
    end

    // Output drive: the inhibit also covers the first cycle of an excess.
    always_comb begin
        rate_code   = code_q;
        ovld        = ovld_q;
        edv_inhibit = ovld_q | above_dbl;
    end
endmodule

// File: rtl/rbm_checker.sv
`timescale 1ns/1ps
// rbm_checker: port-level properties of rate_band_monitor, attached by bind.
module rbm_checker #(
    parameter int CUR_W = 16,
    parameter int CAP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CUR_W-1:0] cur_mag,
    input logic [CAP_W-1:0] cap_full,
    input logic             tick,
    input logic [2:0]       rate_code,
    input logic             ovld,
    input logic             edv_inhibit
);
    logic over_now;
    logic under_half;

    // Independent edge evaluation in wide integer arithmetic.
    always_comb begin
        over_now   = (32'(cur_mag) > 32'(cap_full) * 2);
        under_half = (32'(cur_mag) < 32'(cap_full) / 2);
    end

    // R3
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_code <= 3'd2);

    // R1
    low_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        under_half |=> rate_code == 3'b000);

    // R5
    over_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        over_now |=> (ovld && rate_code == 3'b010));

    // R6
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovld && !tick) |=> ovld);

    // R8
    inhibit_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovld || over_now) |-> edv_inhibit);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rate_code == 3'b000 && !ovld));
endmodule

bind rate_band_monitor rbm_checker #(.CUR_W(CUR_W), .CAP_W(CAP_W)) i_rbm_chk (.*);

// File: tb/test_rate_band_monitor.sv
`timescale 1ns/1ps
module test_rate_band_monitor;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cur_mag = '0;
    logic [CW-1:0] cap_full = '0;
    logic          tick = 1'b0;
    logic [2:0]    rate_code;
    logic          ovld;
    logic          edv_inhibit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rate_band_monitor #(.CUR_W(CW), .CAP_W(CW), .HOLD_TICKS(32)) i_rate_band_monitor (
        .clk(clk), .rst_n(rst_n), .cur_mag(cur_mag), .cap_full(cap_full),
        .tick(tick), .rate_code(rate_code), .ovld(ovld), .edv_inhibit(edv_inhibit)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic pulse_tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic apply(input int cur, input int cap);
        @(negedge clk);
        cur_mag = CW'(cur);
        cap_full = CW'(cap);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 code", rate_code, 0);
        check("R9 ovld", ovld, 0);
        check("R9 inhibit", edv_inhibit, 0);
        rst_n = 1'b1;

        // R1 R2 R3: exhaustive current sweep at several capacities
        foreach (cap_list[i]) begin
            do_reset();
            for (int c = 0; c < 256; c++) begin
                int exp;
                apply(c, cap_list[i]);
                exp = (c > 2 * cap_list[i]) ? 2 : (c >= cap_list[i] / 2) ? 1 : 0;
                check(exp == 2 ? "R3 sweep" : exp == 1 ? "R2 sweep" : "R1 sweep", rate_code, exp);
            end
        end

        // R2 exactly 2C stays mid with no overload
        do_reset();
        apply(80, 40);
        check("R2 equal 2C code", rate_code, 1);
        check("R2 equal 2C ovld", ovld, 0);

        // R8 inhibit is immediate, before the flag is registered
        @(negedge clk) cur_mag = 8'd81;
        #1;
        check("R8 immediate inhibit", edv_inhibit, 1);
        check("R5 flag not yet set", ovld, 0);
        @(negedge clk);
        check("R5 flag set", ovld, 1);
        check("R3 over code", rate_code, 2);

        // R5 ticks during the excess never clear
        pulse_tick(40);
        check("R5 persists", ovld, 1);

        // R6 hold lasts exactly 32 ticks
        @(negedge clk) cur_mag = 8'd10;
        repeat (5) @(negedge clk);
        check("R6 no tick keeps", ovld, 1);
        check("R1 code after drop", rate_code, 0);
        pulse_tick(31);
        check("R6 31 ticks", ovld, 1);
        check("R8 inhibit in hold", edv_inhibit, 1);
        pulse_tick(1);
        check("R6 32 ticks", ovld, 0);
        check("R8 inhibit released", edv_inhibit, 0);

        // R7 restart during hold
        apply(81, 40);
        @(negedge clk) cur_mag = 8'd10;
        pulse_tick(20);
        check("R7 mid hold", ovld, 1);
        apply(90, 40);
        @(negedge clk) cur_mag = 8'd10;
        pulse_tick(31);
        check("R7 restarted 31", ovld, 1);
        pulse_tick(1);
        check("R7 restarted 32", ovld, 0);

        // R4 registered code and capacity retarget
        apply(60, 40);
        check("R4 mid", rate_code, 1);
        @(negedge clk) cap_full = 8'd20;
        #1;
        check("R4 held before edge", rate_code, 1);
        @(negedge clk);
        check("R4 retarget", rate_code, 2);

        // R9 reset mid-hold
        @(negedge clk) cur_mag = 8'd5;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset ovld", ovld, 0);
        check("R9 reset code", rate_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset", ovld, 0);

        done = 1;
    end

    int cap_list[9] = '{0, 1, 2, 7, 40, 63, 100, 127, 200};

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule